// File: doc/BRIEF.md
# Keyed Configuration Register Port

This block is a two-byte, I/O-mapped window into a small configuration register space. Offset 0 is the index port and offset 1 is the data port. After reset the space is sealed. Host software opens it by writing a fixed key byte to the index port on two index writes in a row. It closes the space again with a different single key byte. While the space is open, a write to the index port picks a register, and the data port then reads or writes that register.

The register space has a vendor identity and a part identity, both 16 bits wide, read-only and parameterised. It also has a logical-device selector. A group of upper registers is banked behind that selector. When the selector holds the hardware-monitor device number, two of those registers expose the 16-bit I/O base address of the monitor. The address is writable, and the block drives it out to the rest of the chip.

Each bus access takes one cycle. A write is a one-cycle strobe with an offset and a byte. Read data is a combinational function of the offset and the current state, so reads have no side effects.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the space is sealed (`cfg_open` = 0), the selector reads 0x00, the monitor base is `BASE_RESET` (default 0x0290) and the index holds 0x00.
- R2: Two consecutive index-port writes of 0x87 open the space on the second write. A single 0x87 leaves it sealed.
- R3: An index-port write of any other value between the two 0x87 writes cancels the partial key. Two further 0x87 writes are then needed.
- R4: An index-port write of 0xAA while open seals the space. The index is not changed by it. Data-port writes made after sealing do not reach any register.
- R5: While sealed, both ports read 0xFF and data-port writes are ignored.
- R6: While open, an index-port write of any value other than 0xAA is latched as the index. Reading offset 0 returns that index, and the index survives a seal and reopen.
- R7: The vendor identity reads high byte at index 0x23 and low byte at index 0x24 (default 0x1934).
- R8: The part identity reads high byte at index 0x20 and low byte at index 0x21 (default 0x0406).
- R9: Data-port writes to the identity indices leave their read values unchanged.
- R10: Index 0x07 is the read/write logical-device selector, driven on `ldev_sel`.
- R11: With the selector at 0x04, index 0x60 (high byte) and index 0x61 (low byte) read and write the monitor base, which is driven on `mon_base`.
- R12: With any other selector value, indices 0x60 and 0x61 read 0x00 and writes to them are ignored.
- R13: Unimplemented indices read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_addr | input | 1 | Port offset: 0 = index, 1 = data |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte for the offset on `bus_addr` |
| cfg_open | output | 1 | High while the space is unlocked |
| ldev_sel | output | 8 | Current logical-device selector |
| mon_base | output | 16 | Hardware-monitor I/O base address |

## Verification
The assertions check the lock behaviour on every cycle:
- Both ports read 0xFF whenever the space is sealed.
- The space opens only in the cycle after an index write of 0x87.
- A lock key always seals the space.
- Neither the selector nor the monitor base can move while the space is sealed.

Some behaviour depends on the internal index, which no port shows directly. Only the bench scenarios can demonstrate it:
- the cancelled key sequence;
- the identity byte values and their read-only nature;
- the banking of 0x60 and 0x61 behind the selector;
- the index being kept across a seal and reopen.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

    typedef enum logic [1:0] {
        KEY_SEALED = 2'd0,
        KEY_HALF   = 2'd1,
        KEY_OPEN   = 2'd2
    } key_state_e;

    localparam logic [7:0] KEY_UNLOCK   = 8'h87;
    localparam logic [7:0] KEY_LOCK     = 8'hAA;

    localparam logic [7:0] IDX_LDEV     = 8'h07;
    localparam logic [7:0] IDX_PART_HI  = 8'h20;
    localparam logic [7:0] IDX_PART_LO  = 8'h21;
    localparam logic [7:0] IDX_VEND_HI  = 8'h23;
    localparam logic [7:0] IDX_VEND_LO  = 8'h24;
    localparam logic [7:0] IDX_BASE_HI  = 8'h60;
    localparam logic [7:0] IDX_BASE_LO  = 8'h61;

    localparam logic [7:0] RD_SEALED    = 8'hFF;
    localparam logic [7:0] RD_EMPTY     = 8'h00;

    typedef struct packed {
        logic       wr_idx;
        logic       wr_dat;
        logic [7:0] wdata;
    } bus_op_t;

    function automatic logic [7:0] hi_byte(input logic [15:0] w);
        return w[15:8];
    endfunction

    function automatic logic [7:0] lo_byte(input logic [15:0] w);
        return w[7:0];
    endfunction

endpackage

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
    import sio_cfg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  bus_op_t op,
    output logic    open
);
    key_state_e st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= KEY_SEALED;
        end else if (op.wr_idx) begin
            case (st_q)
                KEY_SEALED: st_q <= (op.wdata == KEY_UNLOCK) ? KEY_HALF : KEY_SEALED;
                KEY_HALF:   st_q <= (op.wdata == KEY_UNLOCK) ? KEY_OPEN : KEY_SEALED;
                KEY_OPEN:   st_q <= (op.wdata == KEY_LOCK)   ? KEY_SEALED : KEY_OPEN;
                default:    st_q <= KEY_SEALED;
            endcase
        end
    end

    assign open = (st_q == KEY_OPEN);
endmodule

// File: rtl/sio_index_latch.sv
module sio_index_latch
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_op_t    op,
    input  logic       open,
    output logic [7:0] idx
);
    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= 8'h00;
        end else if (op.wr_idx && open && (op.wdata != KEY_LOCK)) begin
            idx <= op.wdata;
        end
    end
endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
    import sio_cfg_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID  = 16'h1934,
    parameter logic [15:0] PART_ID    = 16'h0406,
    parameter logic [15:0] BASE_RESET = 16'h0290,
    parameter logic [7:0]  HWMON_LDN  = 8'h04
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [7:0]  idx,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic [7:0]  ldev,
    output logic [15:0] base
);
    logic hw_bank;
    assign hw_bank = (ldev == HWMON_LDN);

    always_ff @(posedge clk) begin
        if (rst) begin
            ldev <= 8'h00;
            base <= BASE_RESET;
        end else if (wr_en) begin
            case (idx)
                IDX_LDEV:    ldev <= wdata;
                IDX_BASE_HI: if (hw_bank) base[15:8] <= wdata;
                IDX_BASE_LO: if (hw_bank) base[7:0]  <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (idx)
            IDX_LDEV:    rdata = ldev;
            IDX_PART_HI: rdata = hi_byte(PART_ID);
            IDX_PART_LO: rdata = lo_byte(PART_ID);
            IDX_VEND_HI: rdata = hi_byte(VENDOR_ID);
            IDX_VEND_LO: rdata = lo_byte(VENDOR_ID);
            IDX_BASE_HI: rdata = hw_bank ? hi_byte(base) : RD_EMPTY;
            IDX_BASE_LO: rdata = hw_bank ? lo_byte(base) : RD_EMPTY;
            default:     rdata = RD_EMPTY;
        endcase
    end
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID  = 16'h1934,
    parameter logic [15:0] PART_ID    = 16'h0406,
    parameter logic [15:0] BASE_RESET = 16'h0290,
    parameter logic [7:0]  HWMON_LDN  = 8'h04
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic        bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        cfg_open,
    output logic [7:0]  ldev_sel,
    output logic [15:0] mon_base
);
    bus_op_t    op;
    logic [7:0] idx;
    logic [7:0] reg_rdata;

    assign op.wr_idx = bus_wr && !bus_addr;
    assign op.wr_dat = bus_wr &&  bus_addr;
    assign op.wdata  = bus_wdata;

    sio_key_fsm u_key (
        .clk  (clk),
        .rst  (rst),
        .op   (op),
        .open (cfg_open)
    );

    sio_index_latch u_idx (
        .clk  (clk),
        .rst  (rst),
        .op   (op),
        .open (cfg_open),
        .idx  (idx)
    );

    sio_cfg_regs #(
        .VENDOR_ID  (VENDOR_ID),
        .PART_ID    (PART_ID),
        .BASE_RESET (BASE_RESET),
        .HWMON_LDN  (HWMON_LDN)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (op.wr_dat && cfg_open),
        .idx   (idx),
        .wdata (bus_wdata),
        .rdata (reg_rdata),
        .ldev  (ldev_sel),
        .base  (mon_base)
    );

    always_comb begin
        if (!cfg_open)     bus_rdata = RD_SEALED;
        else if (bus_addr) bus_rdata = reg_rdata;
        else               bus_rdata = idx;
    end
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk (
    input logic        clk,
    input logic        rst,
    input logic        bus_wr,
    input logic        bus_addr,
    input logic [7:0]  bus_wdata,
    input logic [7:0]  bus_rdata,
    input logic        cfg_open,
    input logic [7:0]  ldev_sel,
    input logic [15:0] mon_base
);
    AST_SEALED_READS_FF: assert property (@(posedge clk) disable iff (rst)
        !cfg_open |-> bus_rdata == 8'hFF);                                   // R5

    AST_OPEN_NEEDS_KEY: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_open) |-> $past(bus_wr && !bus_addr && bus_wdata == 8'h87)); // R2

    AST_NO_KEY_STAYS_SEALED: assert property (@(posedge clk) disable iff (rst)
        (!cfg_open && !(bus_wr && !bus_addr && bus_wdata == 8'h87)) |=> !cfg_open); // R3

    AST_LOCK_KEY_SEALS: assert property (@(posedge clk) disable iff (rst)
        (cfg_open && bus_wr && !bus_addr && bus_wdata == 8'hAA) |=> !cfg_open); // R4

    AST_BASE_HELD_SEALED: assert property (@(posedge clk) disable iff (rst)
        !cfg_open |=> $stable(mon_base));                                    // R5

    AST_LDEV_HELD_SEALED: assert property (@(posedge clk) disable iff (rst)
        !cfg_open |=> $stable(ldev_sel));                                    // R10
endmodule

bind sio_cfg_port sio_cfg_port_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cfg_open  (cfg_open),
    .ldev_sel  (ldev_sel),
    .mon_base  (mon_base)
);

// File: tb/sio_cfg_port_tb.sv
module sio_cfg_port_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic        bus_addr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic        cfg_open;
    logic [7:0]  ldev_sel;
    logic [15:0] mon_base;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    sio_cfg_port u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cfg_open  (cfg_open),
        .ldev_sel  (ldev_sel),
        .mon_base  (mon_base)
    );

    // {req[3:0], write, offset, data, expected read}
    localparam int NV = 47;
    localparam logic [21:0] VEC [NV] = '{
        {4'd1,  1'b0, 1'b1, 8'h00, 8'hFF},  // R1 sealed after reset
        {4'd5,  1'b0, 1'b0, 8'h00, 8'hFF},  // R5 index port sealed
        {4'd5,  1'b1, 1'b1, 8'h55, 8'h00},  // R5 data write while sealed
        {4'd2,  1'b1, 1'b0, 8'h87, 8'h00},  // R2 first key
        {4'd2,  1'b0, 1'b1, 8'h00, 8'hFF},  // R2 one key is not enough
        {4'd3,  1'b1, 1'b0, 8'h12, 8'h00},  // R3 break the sequence
        {4'd3,  1'b1, 1'b0, 8'h87, 8'h00},  // R3
        {4'd3,  1'b0, 1'b0, 8'h00, 8'hFF},  // R3 still sealed
        {4'd2,  1'b1, 1'b0, 8'h87, 8'h00},  // R2 second key opens
        {4'd6,  1'b1, 1'b0, 8'h23, 8'h00},  // R6
        {4'd6,  1'b0, 1'b0, 8'h00, 8'h23},  // R6 index readback
        {4'd7,  1'b0, 1'b1, 8'h00, 8'h19},  // R7 vendor hi
        {4'd7,  1'b1, 1'b0, 8'h24, 8'h00},  // R7
        {4'd7,  1'b0, 1'b1, 8'h00, 8'h34},  // R7 vendor lo
        {4'd8,  1'b1, 1'b0, 8'h20, 8'h00},  // R8
        {4'd8,  1'b0, 1'b1, 8'h00, 8'h04},  // R8 part hi
        {4'd9,  1'b1, 1'b1, 8'hAB, 8'h00},  // R9 write to identity
        {4'd9,  1'b0, 1'b1, 8'h00, 8'h04},  // R9 unchanged
        {4'd8,  1'b1, 1'b0, 8'h21, 8'h00},  // R8
        {4'd8,  1'b0, 1'b1, 8'h00, 8'h06},  // R8 part lo
        {4'd10, 1'b1, 1'b0, 8'h07, 8'h00},  // R10
        {4'd1,  1'b0, 1'b1, 8'h00, 8'h00},  // R1 selector reset value
        {4'd12, 1'b1, 1'b0, 8'h60, 8'h00},  // R12
        {4'd12, 1'b0, 1'b1, 8'h00, 8'h00},  // R12 other bank reads 0
        {4'd12, 1'b1, 1'b1, 8'h77, 8'h00},  // R12 write ignored
        {4'd10, 1'b1, 1'b0, 8'h07, 8'h00},  // R10
        {4'd10, 1'b1, 1'b1, 8'h04, 8'h00},  // R10 select monitor
        {4'd10, 1'b0, 1'b1, 8'h00, 8'h04},  // R10 readback
        {4'd11, 1'b1, 1'b0, 8'h60, 8'h00},  // R11
        {4'd12, 1'b0, 1'b1, 8'h00, 8'h02},  // R12 earlier write had no effect
        {4'd11, 1'b1, 1'b1, 8'h0A, 8'h00},  // R11
        {4'd11, 1'b0, 1'b1, 8'h00, 8'h0A},  // R11 base hi
        {4'd11, 1'b1, 1'b0, 8'h61, 8'h00},  // R11
        {4'd1,  1'b0, 1'b1, 8'h00, 8'h90},  // R1 base lo reset value
        {4'd11, 1'b1, 1'b1, 8'hC0, 8'h00},  // R11
        {4'd11, 1'b0, 1'b1, 8'h00, 8'hC0},  // R11 base lo
        {4'd13, 1'b1, 1'b0, 8'h3F, 8'h00},  // R13
        {4'd13, 1'b0, 1'b1, 8'h00, 8'h00},  // R13 empty index
        {4'd6,  1'b1, 1'b0, 8'h61, 8'h00},  // R6
        {4'd4,  1'b1, 1'b0, 8'hAA, 8'h00},  // R4 lock key
        {4'd4,  1'b0, 1'b1, 8'h00, 8'hFF},  // R4 data sealed
        {4'd4,  1'b0, 1'b0, 8'h00, 8'hFF},  // R4 index sealed
        {4'd4,  1'b1, 1'b1, 8'h11, 8'h00},  // R4 write after seal
        {4'd2,  1'b1, 1'b0, 8'h87, 8'h00},  // R2
        {4'd2,  1'b1, 1'b0, 8'h87, 8'h00},  // R2 reopen
        {4'd6,  1'b0, 1'b0, 8'h00, 8'h61},  // R6 index kept
        {4'd4,  1'b0, 1'b1, 8'h00, 8'hC0}   // R4 sealed write ignored
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        rst = 1'b1; bus_wr = 1'b0; bus_addr = 1'b0; bus_wdata = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 open", {15'd0, cfg_open}, 16'd0);
        check("R1 base", mon_base, 16'h0290);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            bus_wr    = VEC[i][17];
            bus_addr  = VEC[i][16];
            bus_wdata = VEC[i][15:8];
            if (!VEC[i][17]) begin
                #1;
                check($sformatf("R%0d vector %0d", VEC[i][21:18], i),
                      {8'h00, bus_rdata}, {8'h00, VEC[i][7:0]});
            end
        end
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
        check("R11 mon_base port", mon_base, 16'h0AC0);
        check("R10 ldev_sel port", {8'h00, ldev_sel}, 16'h0004);
        check("R2 cfg_open port", {15'd0, cfg_open}, 16'd1);

        // Reset in the middle of an open session
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 reopen sealed", {15'd0, cfg_open}, 16'd0);
        check("R1 base restored", mon_base, 16'h0290);
        check("R1 selector restored", {8'h00, ldev_sel}, 16'h0000);

        // Unlock again and confirm the index returned to zero
        @(negedge clk); bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = 8'h87;
        @(negedge clk); bus_wdata = 8'h87;
        @(negedge clk); bus_wr = 1'b0;
        #1;
        check("R1 index reset", {8'h00, bus_rdata}, 16'h0000);

        // Locking key while only half unlocked keeps the space sealed
        @(negedge clk); bus_wr = 1'b1; bus_wdata = 8'hAA;
        @(negedge clk); bus_wdata = 8'h87;
        @(negedge clk); bus_wdata = 8'hAA;
        @(negedge clk); bus_wdata = 8'h87;
        @(negedge clk); bus_wr = 1'b0;
        #1;
        check("R3 half key then other", {15'd0, cfg_open}, 16'd0);

        @(negedge clk);
        finish_run();
    end
endmodule